// File: doc/BRIEF.md
# Byte-Addressed SPI GPIO Port Expander

This block is an SPI mode-0 target that controls one 8-bit general-purpose I/O port. The serial clock, chip select and data input are taken into the system clock domain through synchronizer stages. All framing decisions are made on edges detected in that domain.

Each frame opens with a device opcode. Its upper nibble is a fixed family code, bits 3:1 select the device sub-address, and bit 0 asks for a read. The next byte loads a register pointer. Every byte after that is written into, or read out of, the register the pointer names. Depending on a configuration bit, the pointer either steps forward after each data byte or stays where it is.

The register file drives three things at the pad side: which pins are outputs, the level each output pin drives, and which pins have a pull-up enabled. Reading the port register returns the synchronized pin levels, with selected bits inverted. Interrupt-on-change detection sits in a separate block. Its three settings registers are held here as plain storage.

Top module: `gpx_spi_expander`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0x00), `pin_out` = 0x00, `pin_pullup` = 0x00 and `spi_miso_oe` = 0. The config register at pointer 0x05 resets to 0x00.
- R2: A frame is accepted only when opcode bits 7:4 equal 0100; opcode bit 0 = 1 selects a read. In a rejected frame, `spi_miso_oe` stays low and no register changes.
- R3: Config bit 3 (pointer 0x05) turns on sub-address checking, comparing opcode bits 3:1 with `strap_addr`. When that bit is 0, opcode bits 3:1 have no effect on acceptance.
- R4: The second byte of a frame is the register pointer. Direction is at 0x00, input polarity at 0x01, pull-up at 0x06 and output latch at 0x0A.
- R5: A 1 in direction bit i makes pin i an input, so `pin_oe[i]` is its inverse. `pin_out` follows the latch, and `pin_pullup` follows register 0x06. Direction resets to 0xFF.
- R6: A read of pointer 0x09 returns the synchronized `pin_in` XOR the polarity register.
- R7: With config bit 5 = 0, the pointer steps by one after each data byte. A pointer at or above 0x0A steps to 0x00.
- R8: With config bit 5 = 1, the pointer holds, so every data byte of the burst accesses the same register.
- R9: The following write cases apply:
  - A write to 0x09 loads the output latch.
  - Writes to 0x07, 0x08 and to pointers above 0x0A are dropped.
  - Reads of 0x07, 0x08 and of pointers above 0x0A return 0x00.
- R10: Raising `spi_csn` ends the frame at once and clears the bit count. A partly received byte is never committed, and the next frame starts with a fresh opcode.
- R11: Read data leaves MSB first, changes after falling clock edges, and has its first bit on `spi_miso` before the first rising edge of each data byte. `spi_miso_oe` rises when the pointer byte of an accepted read frame completes and falls when `spi_csn` goes high.
- R12: Registers 0x02, 0x03, 0x04 and 0x05 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad |
| strap_addr | input | 3 | Board-strapped device sub-address |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables, 1 = driving |
| pin_pullup | output | 8 | Pad pull-up enables |

## Verification
The assertions take four things for granted:
- The serial clock is slow enough that every high and low phase spans several system clocks, so each edge is seen once after synchronization.
- `spi_mosi` is stable for at least the synchronizer depth before each rising edge.
- `pin_in` does not change while a read byte is being loaded.
- A config write never shares a burst with other data bytes.

The stimulus keeps within these limits in the following way. It holds each clock phase for six system clocks and changes data only on falling edges. It changes pin levels only between frames, and it issues config writes as single-byte frames.

// File: rtl/gx_pkg.sv
package gx_pkg;
    localparam int BYTE_W = 8;
    localparam int SUB_W  = 3;
    localparam logic [3:0] OPC_FAMILY = 4'b0100;
    localparam int CFG_HWA_BIT = 3;
    localparam int CFG_SEQ_BIT = 5;

    localparam logic [7:0] RG_DIR  = 8'h00;
    localparam logic [7:0] RG_POL  = 8'h01;
    localparam logic [7:0] RG_IEN  = 8'h02;
    localparam logic [7:0] RG_DEF  = 8'h03;
    localparam logic [7:0] RG_ICON = 8'h04;
    localparam logic [7:0] RG_CFG  = 8'h05;
    localparam logic [7:0] RG_PULL = 8'h06;
    localparam logic [7:0] RG_FLAG = 8'h07;
    localparam logic [7:0] RG_CAP  = 8'h08;
    localparam logic [7:0] RG_PORT = 8'h09;
    localparam logic [7:0] RG_LAT  = 8'h0A;
    localparam logic [7:0] PTR_MAX = RG_LAT;

    typedef enum logic [1:0] {PH_OPC, PH_PTR, PH_DATA, PH_SKIP} phase_e;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gx_spi_shift.sv
module gx_spi_shift
    import gx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
    } sh_t;

    sh_t sh_d, sh_q;
    logic rise, fall;

    always_comb begin
        rise     = !csn_s && sck_s && !sh_q.sck_prev;
        fall     = !csn_s && !sck_s && sh_q.sck_prev;
        rx_valid = rise && (sh_q.cnt == CNT_W'(BYTE_W - 1));
        rx_byte  = {sh_q.rx[BYTE_W-2:0], mosi_s};
        miso_bit = sh_q.tx[BYTE_W-1];

        sh_d          = sh_q;
        sh_d.sck_prev = sck_s;
        if (csn_s) begin
            sh_d.cnt = '0;
        end else if (rise) begin
            sh_d.rx  = {sh_q.rx[BYTE_W-2:0], mosi_s};
            sh_d.cnt = sh_q.cnt + 1'b1;
        end else if (fall && sh_q.cnt != '0) begin
            sh_d.tx = {sh_q.tx[BYTE_W-2:0], 1'b0};
        end
        if (tx_load) sh_d.tx = tx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (sh_q.cnt == '0)); // R10
    AST_LOAD_APART_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !fall); // R11
endmodule

// File: rtl/gx_core.sv
module gx_core
    import gx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [SUB_W-1:0]  strap,
    input  logic [BYTE_W-1:0] pins_s,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              miso_oe,
    output logic [BYTE_W-1:0] dir_o,
    output logic [BYTE_W-1:0] lat_o,
    output logic [BYTE_W-1:0] pull_o
);
    typedef struct packed {
        phase_e            ph;
        logic              rd;
        logic [7:0]        ptr;
        logic              oe;
        logic [BYTE_W-1:0] dir;
        logic [BYTE_W-1:0] pol;
        logic [BYTE_W-1:0] ien;
        logic [BYTE_W-1:0] dflt;
        logic [BYTE_W-1:0] icon;
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] pull;
        logic [BYTE_W-1:0] lat;
    } core_t;

    core_t c_d, c_q;
    logic  hit;

    function automatic logic [BYTE_W-1:0] pick(input core_t s, input logic [7:0] idx,
                                               input logic [BYTE_W-1:0] pins);
        case (idx)
            RG_DIR:  return s.dir;
            RG_POL:  return s.pol;
            RG_IEN:  return s.ien;
            RG_DEF:  return s.dflt;
            RG_ICON: return s.icon;
            RG_CFG:  return s.cfg;
            RG_PULL: return s.pull;
            RG_PORT: return pins ^ s.pol;
            RG_LAT:  return s.lat;
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] step(input logic [7:0] p, input logic hold);
        if (hold)          return p;
        if (p >= PTR_MAX)  return 8'h00;
        return p + 8'h01;
    endfunction

    always_comb begin
        c_d     = c_q;
        tx_load = 1'b0;
        tx_byte = '0;
        hit     = (rx_byte[7:4] == OPC_FAMILY) &&
                  (!c_q.cfg[CFG_HWA_BIT] || rx_byte[3:1] == strap);
        if (csn_s) begin
            c_d.ph = PH_OPC;
            c_d.oe = 1'b0;
        end else if (rx_valid) begin
            case (c_q.ph)
                PH_OPC: begin
                    c_d.rd = rx_byte[0];
                    c_d.ph = hit ? PH_PTR : PH_SKIP;
                end
                PH_PTR: begin
                    c_d.ptr = rx_byte;
                    c_d.ph  = PH_DATA;
                    if (c_q.rd) begin
                        tx_load = 1'b1;
                        tx_byte = pick(c_q, rx_byte, pins_s);
                        c_d.oe  = 1'b1;
                    end
                end
                PH_DATA: begin
                    c_d.ptr = step(c_q.ptr, c_q.cfg[CFG_SEQ_BIT]);
                    if (c_q.rd) begin
                        tx_load = 1'b1;
                        tx_byte = pick(c_q, c_d.ptr, pins_s);
                    end else begin
                        case (c_q.ptr)
                            RG_DIR:  c_d.dir  = rx_byte;
                            RG_POL:  c_d.pol  = rx_byte;
                            RG_IEN:  c_d.ien  = rx_byte;
                            RG_DEF:  c_d.dflt = rx_byte;
                            RG_ICON: c_d.icon = rx_byte;
                            RG_CFG:  c_d.cfg  = rx_byte;
                            RG_PULL: c_d.pull = rx_byte;
                            RG_PORT, RG_LAT: c_d.lat = rx_byte;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.ph  <= PH_OPC;
            c_q.dir <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign miso_oe = c_q.oe;
    assign dir_o   = c_q.dir;
    assign lat_o   = c_q.lat;
    assign pull_o  = c_q.pull;

    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !c_q.oe); // R11
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_SKIP) |-> !c_q.oe); // R2
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !csn_s && c_q.ph == PH_DATA && c_q.cfg[CFG_SEQ_BIT]) |=> $stable(c_q.ptr)); // R8
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !csn_s && c_q.ph == PH_DATA && !c_q.cfg[CFG_SEQ_BIT]) |=> (c_q.ptr <= PTR_MAX)); // R7
    AST_RO_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !csn_s && c_q.ph == PH_DATA && !c_q.rd &&
         (c_q.ptr == RG_FLAG || c_q.ptr == RG_CAP))
        |=> ($stable(c_q.dir) && $stable(c_q.lat) && $stable(c_q.pull) && $stable(c_q.cfg))); // R9
endmodule

// File: rtl/gpx_spi_expander.sv
module gpx_spi_expander
    import gx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [SUB_W-1:0]  strap_addr,
    input  logic [BYTE_W-1:0] pin_in,
    output logic [BYTE_W-1:0] pin_out,
    output logic [BYTE_W-1:0] pin_oe,
    output logic [BYTE_W-1:0] pin_pullup
);
    logic              sck_s, csn_s, mosi_s;
    logic [BYTE_W-1:0] pins_s, rx_byte, tx_byte, dir;
    logic              rx_valid, tx_load, miso_bit;

    gx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync_spi (
        .clk(clk), .rst_n(rst_n),
        .din({spi_sck, spi_csn, spi_mosi}), .dout({sck_s, csn_s, mosi_s}));

    gx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pins_s));

    gx_spi_shift u_shift (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .csn_s(csn_s), .mosi_s(mosi_s),
        .tx_load(tx_load), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .miso_bit(miso_bit));

    gx_core u_core (
        .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .strap(strap_addr), .pins_s(pins_s),
        .tx_load(tx_load), .tx_byte(tx_byte), .miso_oe(spi_miso_oe),
        .dir_o(dir), .lat_o(pin_out), .pull_o(pin_pullup));

    assign pin_oe   = ~dir;
    assign spi_miso = miso_bit & spi_miso_oe;
endmodule

// File: tb/gpx_spi_expander_test.sv
module gpx_spi_expander_test;
    localparam int HALF = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 0, rst_n = 0;
    logic sck = 0, csn = 1, mosi = 0;
    logic spi_miso, spi_miso_oe;
    logic [7:0] pin_in = 8'h00, pin_out, pin_oe, pin_pullup;
    int checks = 0, failures = 0;
    bit quiet = 0, done = 0;
    logic [7:0] mdl [0:10];
    logic [7:0] rxq[$];
    logic       oeq[$];

    always #10 clk = ~clk;

    gpx_spi_expander uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .strap_addr(STRAP),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mrd(input logic [7:0] p);
        if (p == 8'h09) return pin_in ^ mdl[1];
        if (p == 8'h07 || p == 8'h08 || p > 8'h0A) return 8'h00;
        return mdl[p[3:0]];
    endfunction

    function automatic void mwr(input logic [7:0] p, input logic [7:0] v);
        if (p == 8'h09) mdl[10] = v;
        else if (!(p == 8'h07 || p == 8'h08 || p > 8'h0A)) mdl[p[3:0]] = v;
    endfunction

    function automatic logic [7:0] madv(input logic [7:0] p);
        if (mdl[5][5]) return p;
        return (p >= 8'h0A) ? 8'h00 : p + 8'h01;
    endfunction

    task automatic send_bits(input logic [7:0] v, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = v[i];
            repeat (HALF) @(negedge clk);
            r[i] = spi_miso;
            if (i == 7) oeq.push_back(spi_miso_oe);
            sck = 1;
            repeat (HALF) @(negedge clk);
            sck = 0;
        end
    endtask

    task automatic send(input logic [7:0] b[$], input int cut);
        logic [7:0] r;
        quiet = 0;
        rxq.delete();
        oeq.delete();
        @(negedge clk) csn = 0;
        foreach (b[k]) begin
            send_bits(b[k], 8, r);
            rxq.push_back(r);
        end
        if (cut > 0) send_bits(8'hFF, cut, r);
        repeat (HALF) @(negedge clk);
        csn = 1;
        repeat (8) @(negedge clk);
        quiet = 1;
    endtask

    task automatic run(input logic [7:0] b[$], input string tag);
        logic [7:0] exp[$];
        logic [7:0] p, pn;
        bit hit, rdf;
        hit = (b[0][7:4] == 4'b0100) && (!mdl[5][3] || b[0][3:1] == STRAP);
        rdf = b[0][0];
        p = b[1];
        for (int k = 2; k < b.size(); k++) begin
            pn = madv(p);
            if (hit && rdf) exp.push_back(mrd(p));
            else begin
                exp.push_back(8'h00);
                if (hit) mwr(p, b[k]);
            end
            if (hit) p = pn;
        end
        send(b, 0);
        for (int k = 0; k < b.size(); k++) begin
            chk(hit ? "R11" : "R2", {7'b0, oeq[k]}, {7'b0, (k >= 2 && hit && rdf)});
            if (k >= 2 && hit && rdf) chk(tag, rxq[k], exp[k-2]);
        end
    endtask

    always @(negedge clk) begin
        if (quiet && !done) begin
            chk("R5", pin_out, mdl[10]);
            chk("R5", pin_oe, ~mdl[0]);
            chk("R5", pin_pullup, mdl[6]);
            chk("R11", {7'b0, spi_miso_oe}, 8'h00);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) mdl[i] = 8'h00;
        mdl[0] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R1", pin_oe, 8'h00);
        chk("R1", pin_out, 8'h00);
        chk("R1", pin_pullup, 8'h00);
        chk("R1", {7'b0, spi_miso_oe}, 8'h00);
        quiet = 1;
        run('{8'h41, 8'h05, 8'h00}, "R1");

        run('{8'h40, 8'h0A, 8'hA5}, "R5");
        run('{8'h40, 8'h00, 8'hF0}, "R5");
        run('{8'h40, 8'h06, 8'h3C}, "R5");
        chk("R5", pin_out, 8'hA5);
        chk("R5", pin_oe, 8'h0F);
        chk("R5", pin_pullup, 8'h3C);

        run('{8'h40, 8'h02, 8'h11, 8'h22, 8'h33}, "R12");
        run('{8'h41, 8'h02, 8'h00, 8'h00, 8'h00}, "R12");

        pin_in = 8'h5A;
        repeat (4) @(negedge clk);
        run('{8'h40, 8'h01, 8'h0F}, "R6");
        run('{8'h41, 8'h09, 8'h00}, "R6");

        run('{8'h41, 8'h0A, 8'h00, 8'h00}, "R7");
        run('{8'h40, 8'h0A, 8'h3C, 8'hFF}, "R7");
        chk("R7", pin_out, 8'h3C);
        chk("R7", pin_oe, 8'h00);
        run('{8'h41, 8'h00, 8'h00, 8'h00}, "R4");

        run('{8'h40, 8'h09, 8'h81}, "R9");
        chk("R9", pin_out, 8'h81);
        run('{8'h40, 8'h07, 8'hFF, 8'hFF}, "R9");
        run('{8'h41, 8'h07, 8'h00, 8'h00}, "R9");
        run('{8'h40, 8'h20, 8'h77}, "R9");
        run('{8'h41, 8'h20, 8'h00}, "R9");

        run('{8'h50, 8'h0A, 8'h00}, "R2");
        chk("R2", pin_out, 8'h81);
        run('{8'h51, 8'h09, 8'h00, 8'h00}, "R2");

        run('{8'h4E, 8'h06, 8'hC3}, "R3");
        chk("R3", pin_pullup, 8'hC3);
        run('{8'h40, 8'h05, 8'h08}, "R3");
        run('{8'h40, 8'h0A, 8'h00}, "R3");
        chk("R3", pin_out, 8'h81);
        run('{8'h4A, 8'h0A, 8'h42}, "R3");
        chk("R3", pin_out, 8'h42);
        run('{8'h4B, 8'h05, 8'h00}, "R12");

        run('{8'h4A, 8'h05, 8'h28}, "R8");
        run('{8'h4A, 8'h0A, 8'h01, 8'h02, 8'h03}, "R8");
        chk("R8", pin_out, 8'h03);
        chk("R8", pin_oe, 8'h00);
        run('{8'h4B, 8'h0A, 8'h00, 8'h00}, "R8");

        send('{8'h4A, 8'h0A}, 5);
        chk("R10", pin_out, 8'h03);
        run('{8'h4A, 8'h0A, 8'h66}, "R10");
        chk("R10", pin_out, 8'h66);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule